// File: doc/BRIEF.md
# BCD Calendar Register File with Host Snapshot and Load

This block keeps a 24-hour calendar in BCD (century, year, month, date, day of week, hours, minutes, seconds) as two register sets. An internal set advances on a one-cycle seconds tick. Month lengths and leap years are handled in that set. An external set is the copy the host reads. It follows the internal set each cycle unless the host has halted it.

The host uses a byte-wide, SRAM-style request interface over a 19-bit address space. A request whose upper address bits are all ones falls in the top sixteen locations. It is claimed by the clock and never reaches the external SRAM. Any other request is passed on through the SRAM enable.

Two control bits serve the host. A read-halt bit freezes the external set so that a multi-byte read is coherent. A write-halt bit also freezes it, so that new time values can be staged. Clearing the write-halt bit copies the staged values into the internal set. A stop bit in the seconds register holds the count. A power-fail input blocks all access.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the clock registers read ctrl 0x20, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00. Both halt bits and the stop bit are 0.
- R2: A request whose address bits [18:4] are all ones is a clock access at offset addr[3:0], and sram_en_o stays low for it. Any other request with power good drives sram_en_o high. The register offsets are: 8 ctrl (bit 7 write-halt, bit 6 read-halt, bits 5:0 century), 9 seconds (bit 7 stop), A minutes, B hours, C day, D date, E month, F year. Offsets 0 to 7 read 0x00, and writes to them have no effect.
- R3: While the stop bit is 0, each tick_i advances the internal set by one second, with seconds and minutes running 00 to 59 and hours 00 to 23, each carrying into the next field.
- R4: While read-halt is 1 and write-halt is 0, the external set holds the value it had when read-halt was written, even though ticks continue.
- R5: With both halt bits at 0, the external set equals the internal set of the previous cycle. After read-halt clears, it shows the seconds counted during the freeze.
- R6: While write-halt is 1, writes to offsets 9 to F (seconds bits 6:0) and to the century bits of ctrl are stored in the external set. A ctrl write with bit 7 at 0 while write-halt is 1 copies the external set into the internal set, taking the century from bits 5:0 of that write.
- R7: While write-halt is 0, writes to offsets 9 to F do not change the time that is read back. Only the stop bit of a seconds write takes effect.
- R8: Seconds bit 7 can be written at any time. While it is 1, ticks do not advance the internal set, and it reads back in bit 7 of offset 9.
- R9: At midnight the day of week steps 1 to 7 and wraps from 7 to 1. The date wraps to 01 after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months except February.
- R10: February ends on day 29 when the year is a nonzero multiple of 4, or when the year is 00 and the century is a multiple of 4. Otherwise it ends on day 28, so 2000 is leap and 2100 is not. Month 12 wraps to 01, and year 99 wraps to 00 and increments the BCD century.
- R11: While pfail_i is 1, reads return 0x00, sram_en_o is low, and writes change nothing.
- R12: rdata_o is 0x00 whenever there is no clock read (no request, a write, or a non-clock address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| pfail_i | input | 1 | Power-fail inhibit, active high |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (19) | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the request cycle |
| sram_en_o | output | 1 | Pass-through enable to the external SRAM |

## Verification
On every cycle the assertions check several behaviours: the freeze of the external set under read-halt, the one-cycle tracking when no halt is set, the copy on a load, the hold under the stop bit, the one-second step on each enabled tick, and the blocking of outputs and control state under power-fail. Calendar arithmetic depends on particular dates, which only the bench scenarios reach. These cover 30- and 31-day month ends, February in 2024, 2023, 2000 and 2100, and the century carry at 1999-12-31. The bench's reference model predicts every read and SRAM enable, and this also exposes offset decoding errors and halt-bit interactions.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } cal_t;

  localparam cal_t CAL_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
                                 wday: 8'h01, hour: 8'h00, minute: 8'h00, second: 8'h00};

  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_SEC  = 4'h9;
  localparam logic [3:0] OFF_MIN  = 4'hA;
  localparam logic [3:0] OFF_HOUR = 4'hB;
  localparam logic [3:0] OFF_WDAY = 4'hC;
  localparam logic [3:0] OFF_DATE = 4'hD;
  localparam logic [3:0] OFF_MON  = 4'hE;
  localparam logic [3:0] OFF_YEAR = 4'hF;

  // BCD increment with wrap from last to first
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
  parameter int ADDR_W = 19,
  parameter int OFF_W  = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              pfail_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFF_W-1:0]  off_o,
  output logic              clk_wr_o,
  output logic              clk_rd_o,
  output logic              sram_en_o
);
  logic hit, live;

  assign hit       = &addr_i[ADDR_W-1:OFF_W];
  assign live      = req_i & ~pfail_i;
  assign off_o     = addr_i[OFF_W-1:0];
  assign clk_wr_o  = live & hit & we_i;
  assign clk_rd_o  = live & hit & ~we_i;
  assign sram_en_o = live & ~hit;
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  input  logic [4:0] cent_lo_i,
  output logic [7:0] last_o
);
  logic [1:0] ymod, cmod;
  logic       leap;

  // BCD value mod 4 = (2*tens + ones) mod 4
  assign ymod = {year_i[4], 1'b0} + year_i[1:0];
  assign cmod = {cent_lo_i[4], 1'b0} + cent_lo_i[1:0];
  assign leap = (year_i == 8'h00) ? (cmod == 2'd0) : (ymod == 2'd0);

  always_comb begin
    unique case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  localparam int N_TOD = 3;
  localparam logic [N_TOD*8-1:0] TOD_LAST = {8'h23, 8'h59, 8'h59};

  logic [N_TOD-1:0][7:0] tod_cur, tod_nxt;
  logic [N_TOD-1:0]      tod_end;
  logic [7:0]            last_date;
  logic                  day_roll, mon_roll, yr_roll, cen_roll;

  assign tod_cur[0] = cur_i.second;
  assign tod_cur[1] = cur_i.minute;
  assign tod_cur[2] = cur_i.hour;

  for (genvar i = 0; i < N_TOD; i++) begin : g_tod
    logic en;
    if (i == 0) begin : g_first
      assign en = 1'b1;
    end else begin : g_rest
      assign en = &tod_end[i-1:0];
    end
    assign tod_end[i] = (tod_cur[i] == TOD_LAST[i*8 +: 8]);
    assign tod_nxt[i] = en ? bcd_next(tod_cur[i], TOD_LAST[i*8 +: 8], 8'h00) : tod_cur[i];
  end

  rtc_month_len u_mlen (
    .month_i  (cur_i.month),
    .year_i   (cur_i.year),
    .cent_lo_i(cur_i.cent[4:0]),
    .last_o   (last_date)
  );

  assign day_roll = &tod_end;
  assign mon_roll = day_roll && (cur_i.date == last_date);
  assign yr_roll  = mon_roll && (cur_i.month == 8'h12);
  assign cen_roll = yr_roll && (cur_i.year == 8'h99);

  always_comb begin
    nxt_o.second = tod_nxt[0];
    nxt_o.minute = tod_nxt[1];
    nxt_o.hour   = tod_nxt[2];
    nxt_o.wday   = !day_roll ? cur_i.wday : ((cur_i.wday == 8'h07) ? 8'h01 : cur_i.wday + 8'h01);
    nxt_o.date   = day_roll ? bcd_next(cur_i.date, last_date, 8'h01) : cur_i.date;
    nxt_o.month  = mon_roll ? bcd_next(cur_i.month, 8'h12, 8'h01) : cur_i.month;
    nxt_o.year   = yr_roll  ? bcd_next(cur_i.year, 8'h99, 8'h00) : cur_i.year;
    nxt_o.cent   = cen_roll ? bcd_next(cur_i.cent, 8'h39, 8'h00) : cur_i.cent;
  end
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pfail_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sram_en_o
);
  localparam int OFF_W = 4;

  logic [OFF_W-1:0] off;
  logic             clk_wr, clk_rd, ctrl_wr, load_w;
  logic             wr_halt_q, rd_halt_q, osc_stop_q;
  cal_t             int_q, int_d, ext_q, ext_d, adv;

  rtc_bus_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .pfail_i  (pfail_i),
    .addr_i   (addr_i),
    .off_o    (off),
    .clk_wr_o (clk_wr),
    .clk_rd_o (clk_rd),
    .sram_en_o(sram_en_o)
  );

  rtc_cal_advance u_adv (
    .cur_i(int_q),
    .nxt_o(adv)
  );

  assign ctrl_wr = clk_wr && (off == OFF_CTRL);
  assign load_w  = ctrl_wr && wr_halt_q && !wdata_i[7];

  always_comb begin
    int_d = int_q;
    if (load_w) begin
      int_d      = ext_q;
      int_d.cent = {2'b00, wdata_i[5:0]};
    end else if (tick_i && !osc_stop_q) begin
      int_d = adv;
    end
  end

  always_comb begin
    ext_d = ext_q;
    if (wr_halt_q) begin
      if (clk_wr) begin
        unique case (off)
          OFF_CTRL: ext_d.cent   = {2'b00, wdata_i[5:0]};
          OFF_SEC:  ext_d.second = {1'b0, wdata_i[6:0]};
          OFF_MIN:  ext_d.minute = wdata_i;
          OFF_HOUR: ext_d.hour   = wdata_i;
          OFF_WDAY: ext_d.wday   = wdata_i;
          OFF_DATE: ext_d.date   = wdata_i;
          OFF_MON:  ext_d.month  = wdata_i;
          OFF_YEAR: ext_d.year   = wdata_i;
          default: ;
        endcase
      end
    end else if (!rd_halt_q) begin
      ext_d = int_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q      <= CAL_RESET;
      ext_q      <= CAL_RESET;
      wr_halt_q  <= 1'b0;
      rd_halt_q  <= 1'b0;
      osc_stop_q <= 1'b0;
    end else begin
      int_q <= int_d;
      ext_q <= ext_d;
      if (ctrl_wr) begin
        wr_halt_q <= wdata_i[7];
        rd_halt_q <= wdata_i[6];
      end
      if (clk_wr && (off == OFF_SEC)) osc_stop_q <= wdata_i[7];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (clk_rd) begin
      unique case (off)
        OFF_CTRL: rdata_o = {wr_halt_q, rd_halt_q, ext_q.cent[5:0]};
        OFF_SEC:  rdata_o = {osc_stop_q, ext_q.second[6:0]};
        OFF_MIN:  rdata_o = ext_q.minute;
        OFF_HOUR: rdata_o = ext_q.hour;
        OFF_WDAY: rdata_o = ext_q.wday;
        OFF_DATE: rdata_o = ext_q.date;
        OFF_MON:  rdata_o = ext_q.month;
        OFF_YEAR: rdata_o = ext_q.year;
        default:  rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       pfail_i,
  input logic [7:0] rdata_o,
  input logic       sram_en_o,
  input cal_t       int_q,
  input cal_t       ext_q,
  input logic       wr_halt_q,
  input logic       rd_halt_q,
  input logic       osc_stop_q,
  input logic       load_w
);
  p_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !osc_stop_q && !load_w) |=> (int_q != $past(int_q)));

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_halt_q && !wr_halt_q) |=> $stable(ext_q));

  p_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_halt_q && !wr_halt_q) |=> (ext_q == $past(int_q)));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (int_q.second == $past(ext_q.second) && int_q.date == $past(ext_q.date)
                && int_q.year == $past(ext_q.year)));

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_stop_q && !load_w) |=> $stable(int_q));

  p_block_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_i |-> (!sram_en_o && rdata_o == 8'h00));

  p_block_ctl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_i |=> $stable({wr_halt_q, rd_halt_q, osc_stop_q}));
endmodule

bind rtc_calendar_regs rtc_calendar_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .pfail_i   (pfail_i),
  .rdata_o   (rdata_o),
  .sram_en_o (sram_en_o),
  .int_q     (int_q),
  .ext_q     (ext_q),
  .wr_halt_q (wr_halt_q),
  .rd_halt_q (rd_halt_q),
  .osc_stop_q(osc_stop_q),
  .load_w    (load_w)
);

// File: tb/sim_rtc_calendar_regs.sv
module sim_rtc_calendar_regs;
  localparam int CLK_P = 10;
  localparam int AW = 19;
  localparam logic [AW-5:0] HI = '1;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pfail = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic          sram_en;

  always #(CLK_P/2) clk = ~clk;

  rtc_calendar_regs #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pfail_i(pfail), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sram_en_o(sram_en));

  int n_chk = 0, n_fail = 0;
  bit done = 0, pf_mode = 0;
  // model index: 0 cent, 1 year, 2 month, 3 date, 4 wday, 5 hour, 6 minute, 7 second
  int m_int[8], m_ext[8], n_int[8], n_ext[8];
  bit m_w, m_r, m_osc;

  function automatic int fb(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] tobcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int dim(input int mo, input int yr, input int ce);
    int full = ce * 100 + yr;
    if (mo == 2) return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int fidx(input logic [3:0] o);
    case (o)
      4'h9: return 7; 4'hA: return 6; 4'hB: return 5; 4'hC: return 4;
      4'hD: return 3; 4'hE: return 2; 4'hF: return 1; default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] o);
    logic [7:0] t;
    t = tobcd(m_ext[fidx(o)]);
    if (o == 4'h8) return {m_w, m_r, t[5:0]};
    if (o == 4'h9) return {m_osc, t[6:0]};
    return t;
  endfunction

  task automatic model_tick();
    n_int[7]++;
    if (n_int[7] == 60) begin
      n_int[7] = 0; n_int[6]++;
      if (n_int[6] == 60) begin
        n_int[6] = 0; n_int[5]++;
        if (n_int[5] == 24) begin
          n_int[5] = 0;
          n_int[4] = (n_int[4] == 7) ? 1 : n_int[4] + 1;
          n_int[3]++;
          if (n_int[3] > dim(n_int[2], n_int[1], n_int[0])) begin
            n_int[3] = 1; n_int[2]++;
            if (n_int[2] == 13) begin
              n_int[2] = 1; n_int[1]++;
              if (n_int[1] == 100) begin
                n_int[1] = 0; n_int[0] = (n_int[0] + 1) % 40;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input bit rq, input bit w, input logic [AW-1:0] a, input logic [7:0] d,
                      input bit tk, input string tag);
    bit hit, acc, cw, es;
    logic [3:0] o;
    logic [7:0] er;
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; tick = tk; pfail = pf_mode;
    #(CLK_P/4);
    hit = (a[AW-1:4] == HI);
    acc = rq && !pf_mode;
    o   = a[3:0];
    es  = acc && !hit;
    er  = (acc && hit && !w && o >= 4'h8) ? exp_rd(o) : 8'h00;
    check(pf_mode ? "R11" : "R2", {7'b0, sram_en}, {7'b0, es});
    check(tag, rdata, er);
    cw = acc && hit && w;
    n_int = m_int;
    n_ext = m_ext;
    if (cw && o == 4'h8 && m_w && !d[7]) begin
      n_int = m_ext;
      n_int[0] = fb({2'b00, d[5:0]});
    end else if (tk && !m_osc) begin
      model_tick();
    end
    if (m_w) begin
      if (cw && o >= 4'h8) begin
        if (o == 4'h8) n_ext[0] = fb({2'b00, d[5:0]});
        else if (o == 4'h9) n_ext[7] = fb({1'b0, d[6:0]});
        else n_ext[fidx(o)] = fb(d);
      end
    end else if (!m_r) begin
      n_ext = m_int;
    end
    if (cw && o == 4'h8) begin m_w = d[7]; m_r = d[6]; end
    if (cw && o == 4'h9) m_osc = d[7];
    m_int = n_int;
    m_ext = n_ext;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, {HI, o}, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] o, input string tag);
    step(1'b1, 1'b0, {HI, o}, 8'h00, 1'b0, tag);
  endtask

  task automatic rd_all(input string tag);
    for (int k = 8; k < 16; k++) rd(4'(k), tag);
  endtask

  task automatic set_time(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                          input logic [7:0] dt, input logic [7:0] wd, input logic [7:0] h,
                          input logic [7:0] mi, input logic [7:0] s);
    wr(4'h8, 8'h80, "R6");
    wr(4'h9, s, "R6");   wr(4'hA, mi, "R6"); wr(4'hB, h, "R6");  wr(4'hC, wd, "R6");
    wr(4'hD, dt, "R6");  wr(4'hE, mo, "R6"); wr(4'hF, y, "R6");
    wr(4'h8, c, "R6");
    rd_all("R6");
  endtask

  task automatic roll(input string tag);
    step(1'b0, 1'b0, '0, 8'h00, 1'b1, tag);
    step(1'b0, 1'b0, '0, 8'h00, 1'b0, tag);
    rd_all(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    m_int = '{20, 0, 1, 1, 1, 0, 0, 0};
    m_ext = m_int;
    m_w = 0; m_r = 0; m_osc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd_all("R1");

    for (int k = 0; k < 70; k++) step(1'b1, 1'b0, {HI, (k % 2 == 0) ? 4'h9 : 4'hA}, 8'h00, 1'b1, "R3");

    wr(4'h8, 8'h40, "R4");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, {HI, 4'h9}, 8'h00, 1'b1, "R4");
    rd_all("R4");
    wr(4'h8, 8'h00, "R5");
    for (int k = 0; k < 3; k++) rd(4'h9, "R5");
    rd_all("R5");

    wr(4'hA, 8'h33, "R7"); rd(4'hA, "R7");
    wr(4'hF, 8'h55, "R7"); rd_all("R7");

    wr(4'h9, 8'h80, "R8");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, {HI, 4'h9}, 8'h00, 1'b1, "R8");
    wr(4'h9, 8'h00, "R8");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, {HI, 4'h9}, 8'h00, 1'b1, "R8");

    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59); roll("R9");
    set_time(8'h20, 8'h24, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59); roll("R9");
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); roll("R10");
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59); roll("R10");
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59); roll("R10");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); roll("R10");
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59); roll("R10");
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59); roll("R10");

    rd(4'h3, "R2");
    wr(4'h3, 8'hFF, "R2");
    rd(4'h3, "R2");
    rd_all("R2");
    step(1'b1, 1'b0, 19'h12345, 8'h00, 1'b0, "R2");
    step(1'b1, 1'b1, 19'h7FFEF, 8'hAA, 1'b0, "R2");

    step(1'b0, 1'b0, {HI, 4'h9}, 8'h00, 1'b0, "R12");
    step(1'b1, 1'b1, {HI, 4'h9}, 8'h00, 1'b0, "R12");
    step(1'b1, 1'b0, 19'h00010, 8'h00, 1'b0, "R12");

    pf_mode = 1;
    wr(4'h8, 8'hC0, "R11");
    wr(4'h9, 8'h80, "R11");
    rd(4'h9, "R11");
    step(1'b1, 1'b0, 19'h00100, 8'h00, 1'b1, "R11");
    pf_mode = 0;
    rd(4'h8, "R11");
    rd(4'h9, "R11");
    rd_all("R11");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule